// File: doc/BRIEF.md
# Cascadable Up/Down Binary Counter

This block is a small binary counter that steps once per rising clock edge, upward or downward as a single direction line selects, whenever its active-low enable is held low. An active-low load input overrides everything. While it is low, the outputs follow the parallel data inputs at once, whatever the clock is doing. This lets the counter be preset to any value, for example to shorten its cycle and build a modulo-N divider.

Two cascade outputs let several counters be chained with no glue logic. A terminal flag is high for the whole cycle in which the count sits at the boundary for the present direction: all ones when counting up, zero when counting down. An active-low carry pulse repeats that condition but only during the low phase of the clock. Wiring each stage's carry into the next stage's enable, with one shared clock, builds a wider synchronous counter.

Top module: `upDownCounter4`

## Requirements
- R1: The stored count changes only on a rising clock edge, and only when enN was low at that edge; with enN high the count holds.
- R2: With downSel low (0 = up) each enabled edge adds one, wrapping from 15 to 0 (13, 14, 15, 0, 1, 2).
- R3: With downSel high (1 = down) each enabled edge subtracts one, wrapping from 0 to 15 (2, 1, 0, 15, 14, 13).
- R4: Changing enN or downSel between rising edges leaves countOut unchanged until the next rising edge.
- R5: While loadN is low, countOut equals dataIn within the same time step, whatever the clock level, and follows dataIn when it changes.
- R6: Load overrides counting: an enabled rising edge with loadN low leaves countOut at dataIn. The value kept on release is dataIn as it stood at the last fall of loadN or the last rising edge while it was low. The first enabled edge after release counts from that value.
- R7: termFlag is high exactly when countOut is 15 with downSel low, or 0 with downSel high; the level of enN has no effect on it.
- R8: carryN is low exactly when termFlag is high and clk is low; otherwise it is high.
- R9: Two instances sharing a clock, the first stage's carryN driving the second stage's enN, count as one 8-bit counter (second stage is the upper nibble) both up and down, across the nibble boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock, rising edge active |
| loadN | input | 1 | Active-low asynchronous parallel load |
| enN | input | 1 | Active-low count enable |
| downSel | input | 1 | Direction: 0 counts up, 1 counts down |
| dataIn | input | 4 | Parallel preset value |
| countOut | output | 4 | Present count |
| termFlag | output | 1 | High while the count is at the boundary for the present direction |
| carryN | output | 1 | Active-low cascade pulse: terminal condition during clock low phase |

## Verification
The two functions that can meet in one cycle are the parallel load and an enabled count edge. The bench lowers loadN just after a rising edge with enN low, keeps it low across the next rising edge, and judges that the output still shows the preset value rather than the preset plus one. It then releases the load in the clock low phase and expects exactly one step from the preset on the following edge. A second overlap, the terminal flag against the carry gating, is judged by sampling both outputs in the high and in the low clock phase at each boundary value.

// File: rtl/upDownCounterPkg.sv
package upDownCounterPkg;

  // Strobes passed from the control to the datapath each cycle.
  typedef struct packed {
    logic advance;  // take a step on the next rising edge
    logic down;     // step direction: 1 = decrement
  } stepCtrl_t;

endpackage

// File: rtl/upDownCtrl.sv
module upDownCtrl
  import upDownCounterPkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             loadN,
  input  logic             enN,
  input  logic             downSel,
  input  logic [WIDTH-1:0] countIn,
  output stepCtrl_t        strobe,
  output logic             termFlag,
  output logic             carryN
);

  localparam logic [WIDTH-1:0] TopVal    = '1;
  localparam logic [WIDTH-1:0] BottomVal = '0;

  logic atTop;
  logic atBottom;

  always_comb begin
    strobe.advance = ~enN;
    strobe.down    = downSel;
  end

  assign atTop    = (countIn == TopVal);
  assign atBottom = (countIn == BottomVal);

  // Boundary for the selected direction; independent of the enable.
  assign termFlag = downSel ? atBottom : atTop;

  // Carry only in the low clock phase so a chained stage sees it at its edge.
  assign carryN = ~(termFlag & ~clk);

  // R7: the flag is only ever raised at one of the two boundary values
  a_r7_term_boundary: assert property (@(posedge clk) disable iff (!loadN)
    termFlag |-> (countIn == TopVal || countIn == BottomVal));

  // R8: just before each rising edge the clock is low, so carry mirrors flag
  a_r8_carry_low: assert property (@(posedge clk) disable iff (!loadN)
    termFlag |-> !carryN);

  a_r8_carry_idle: assert property (@(posedge clk) disable iff (!loadN)
    !termFlag |-> carryN);

endmodule

// File: rtl/upDownPath.sv
module upDownPath
  import upDownCounterPkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             loadN,
  input  logic [WIDTH-1:0] dataIn,
  input  stepCtrl_t        strobe,
  output logic [WIDTH-1:0] countOut
);

  localparam logic [WIDTH-1:0] StepOne = WIDTH'(1);

  logic [WIDTH-1:0] countReg;
  logic [WIDTH-1:0] incVal;
  logic [WIDTH-1:0] decVal;
  logic [WIDTH-1:0] nextVal;

  assign incVal  = countReg + StepOne;
  assign decVal  = countReg - StepOne;
  assign nextVal = strobe.down ? decVal : incVal;

  // Load acts as an asynchronous preset and also refreshes on each edge
  // while it is held low.
  always_ff @(posedge clk or negedge loadN) begin
    if (!loadN)
      countReg <= dataIn;
    else if (strobe.advance)
      countReg <= nextVal;
  end

  // Transparent path while load is low.
  assign countOut = loadN ? countReg : dataIn;

  // R1: no enable, no change
  a_r1_hold: assert property (@(posedge clk) disable iff (!loadN)
    !strobe.advance |=> $stable(countReg));

  // R2: enabled upward step, modular
  a_r2_step_up: assert property (@(posedge clk) disable iff (!loadN)
    (strobe.advance && !strobe.down) |=> countReg == WIDTH'($past(countReg) + StepOne));

  // R3: enabled downward step, modular
  a_r3_step_down: assert property (@(posedge clk) disable iff (!loadN)
    (strobe.advance && strobe.down) |=> countReg == WIDTH'($past(countReg) - StepOne));

endmodule

// File: rtl/upDownCounter4.sv
module upDownCounter4
  import upDownCounterPkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             loadN,
  input  logic             enN,
  input  logic             downSel,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] countOut,
  output logic             termFlag,
  output logic             carryN
);

  stepCtrl_t stepStrobe;

  upDownCtrl #(.WIDTH(WIDTH)) ctrl (
    .clk      (clk),
    .loadN    (loadN),
    .enN      (enN),
    .downSel  (downSel),
    .countIn  (countOut),
    .strobe   (stepStrobe),
    .termFlag (termFlag),
    .carryN   (carryN)
  );

  upDownPath #(.WIDTH(WIDTH)) path (
    .clk      (clk),
    .loadN    (loadN),
    .dataIn   (dataIn),
    .strobe   (stepStrobe),
    .countOut (countOut)
  );

endmodule

// File: tb/upDownCounter4_test.sv
module upDownCounter4_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       loadN, enN, downSel;
  logic [3:0] dataIn;
  logic [3:0] countOut;
  logic       termFlag, carryN;

  // cascade pair
  logic       casLoadN, casEnN, casDown;
  logic [7:0] casData;
  logic [3:0] loCount, hiCount;
  logic       loTerm, hiTerm, loCarryN, hiCarryN;
  logic       linkEnN;

  int checkCount = 0;
  int failCount  = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  upDownCounter4 uut (
    .clk(clk), .loadN(loadN), .enN(enN), .downSel(downSel), .dataIn(dataIn),
    .countOut(countOut), .termFlag(termFlag), .carryN(carryN)
  );

  // Small wire delay on the link models hold time at the next stage.
  assign #2 linkEnN = loCarryN;

  upDownCounter4 stageLo (
    .clk(clk), .loadN(casLoadN), .enN(casEnN), .downSel(casDown), .dataIn(casData[3:0]),
    .countOut(loCount), .termFlag(loTerm), .carryN(loCarryN)
  );

  upDownCounter4 stageHi (
    .clk(clk), .loadN(casLoadN), .enN(linkEnN), .downSel(casDown), .dataIn(casData[7:4]),
    .countOut(hiCount), .termFlag(hiTerm), .carryN(hiCarryN)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // after a rising edge, in the clock high phase
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // into the clock low phase
  task automatic toLow();
    @(negedge clk);
    #1;
  endtask

  task automatic testLoad();
    loadN = 0; dataIn = 4'd13; enN = 1; downSel = 0;
    #1 check("R5 load passes data", 8'(countOut), 8'd13);
    dataIn = 4'd6;
    #1 check("R5 follows data change", 8'(countOut), 8'd6);
    dataIn = 4'd13;
    tick();
    toLow();
    loadN = 1;
    #1 check("R6 value kept on release", 8'(countOut), 8'd13);
  endtask

  task automatic testCountUp();
    logic [3:0] expv;
    expv = 4'd13;
    enN = 0; downSel = 0;
    for (int i = 0; i < 5; i++) begin
      tick();
      expv = expv + 4'd1;
      check("R2 up step with wrap", 8'(countOut), 8'(expv));
    end
  endtask

  task automatic testHoldAndControls();
    toLow();
    enN = 1;
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R1 hold with enN high", 8'(countOut), 8'd2);
    end
    enN = 0;
    #2 check("R4 enable change mid-cycle", 8'(countOut), 8'd2);
    downSel = 1;
    #1 check("R4 direction change mid-cycle", 8'(countOut), 8'd2);
    toLow();
    check("R4 still held in low phase", 8'(countOut), 8'd2);
  endtask

  task automatic testCountDown();
    logic [3:0] expv;
    expv = 4'd2;
    for (int i = 0; i < 5; i++) begin
      tick();
      expv = expv - 4'd1;
      check("R3 down step with wrap", 8'(countOut), 8'(expv));
    end
  endtask

  task automatic testTerminal();
    toLow();
    enN = 1; downSel = 0; loadN = 0; dataIn = 4'd15;
    tick();
    toLow();
    loadN = 1;
    tick();
    check("R7 flag at 15 up", 8'(termFlag), 8'd1);
    check("R8 carry high in high phase", 8'(carryN), 8'd1);
    toLow();
    check("R8 carry low in low phase", 8'(carryN), 8'd0);
    downSel = 1;
    #1 check("R7 no flag at 15 down", 8'(termFlag), 8'd0);
    check("R8 carry idle without flag", 8'(carryN), 8'd1);
    loadN = 0; dataIn = 4'd0;
    #1 check("R7 flag at 0 down", 8'(termFlag), 8'd1);
    tick();
    toLow();
    loadN = 1;
    #1 check("R8 carry low at 0 down", 8'(carryN), 8'd0);
    enN = 0;
    #1 check("R7 flag ignores enable", 8'(termFlag), 8'd1);
    downSel = 0;
    #1 check("R7 no flag at 0 up", 8'(termFlag), 8'd0);
    enN = 1;
  endtask

  task automatic testLoadOverCount();
    tick();
    enN = 0; downSel = 0; loadN = 0; dataIn = 4'd9;
    #1 check("R5 load in clock high phase", 8'(countOut), 8'd9);
    tick();
    check("R6 load beats enabled edge", 8'(countOut), 8'd9);
    toLow();
    loadN = 1;
    tick();
    check("R6 first edge counts from preset", 8'(countOut), 8'd10);
    enN = 1;
  endtask

  task automatic testCascade();
    logic [7:0] expv;
    toLow();
    casLoadN = 0; casEnN = 1; casDown = 0; casData = 8'hFD;
    tick();
    toLow();
    casLoadN = 1;
    casEnN = 0;
    expv = 8'hFD;
    check("R9 cascade preset", {hiCount, loCount}, expv);
    for (int i = 0; i < 6; i++) begin
      tick();
      expv = expv + 8'd1;
      check("R9 cascade up", {hiCount, loCount}, expv);
    end
    toLow();
    casDown = 1;
    for (int i = 0; i < 6; i++) begin
      tick();
      expv = expv - 8'd1;
      check("R9 cascade down", {hiCount, loCount}, expv);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
  endtask

  initial begin
    loadN = 0; enN = 1; downSel = 0; dataIn = 4'd0;
    casLoadN = 0; casEnN = 1; casDown = 0; casData = 8'h00;
    testLoad();
    testCountUp();
    testHoldAndControls();
    testCountDown();
    testTerminal();
    testLoadOverCount();
    testCascade();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule